// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Host Port with Bus-Style Detection

This block connects a small byte-wide storage array to a host over an 8-bit bus that carries the address first and the data afterwards. An address strobe separates the two phases: the address is taken from the bus when the strobe falls. At that same moment the port samples the level of the data-strobe pin to find out which of two bus styles the host uses. In the first style the data strobe is an active-high enable and a read/write level says whether the cycle reads or writes. In the second style the data-strobe pin is an active-low read enable and the read/write pin is an active-low write pulse. The style is detected again on every bus cycle.

All bus pins are brought into a fast internal clock domain through two-stage synchronisers. Strobe edges are found from the synchronised values. The port produces the read enable, a one-cycle write strobe with its data, and an output enable for the external bus drivers. The bus is given as separate input, output and enable vectors. A 64-byte register file serves as the storage behind the port.

Top module: `mbp_host_port`

## Requirements
- R1: The bus address is captured when the synchronised address strobe falls. Bits 5:0 select one of 64 bytes. The captured address stays in force until the next fall of the address strobe, whatever the bus carries in the meantime.
- R2: The data-strobe level captured at the address-strobe fall picks the bus style: low picks level style, high picks pulse style. The style is held until the next address-strobe fall.
- R3: In level style the port drives the addressed byte on the bus (output enable 1) while the data strobe is high and the read/write pin is high.
- R4: In level style, a write happens when the data strobe falls after being high with the read/write pin low. The byte stored is the last bus value present before that fall.
- R5: In pulse style the port drives the addressed byte while the data-strobe pin is low and the read/write pin is high.
- R6: In pulse style, a write happens when the read/write pin rises after being low. The byte stored is the last bus value present before that rise.
- R7: The output enable is 0 while the address strobe is high and while a write strobe is active.
- R8: An address of 64 or above (bits 7:6 not both 0) is ignored on writes, and no stored byte changes. A read at such an address drives 0x00.
- R9: The active-low chip select is sampled at the address-strobe fall. When it is high, the cycle neither writes nor drives the bus.
- R10: After reset the output enable is 0 and every stored byte reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_as | input | 1 | Address strobe; address captured on its fall |
| bus_ds | input | 1 | Data strobe (level style) or active-low read (pulse style) |
| bus_rw | input | 1 | Read/write level (level style) or active-low write (pulse style) |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_ad_in | input | 8 | Address/data bus as seen at the pins |
| bus_ad_out | output | 8 | Read data to drive onto the bus |
| bus_ad_oe | output | 1 | Enable for the bus output drivers |

## Verification
The whole in-range address space is written in one bus style and read back in the other, and then the other way round. A mismatch therefore shows whether the style decode, the address latch or the capture edge is at fault, and not just a fault in one style. Each write first puts a wrong byte on the bus and then changes it to the correct byte, which shows whether data is captured at the trailing edge or too early. After the address strobe falls, the bus carries the inverted address, which separates a latched address from a live one. Out-of-range addresses, deselected cycles and cycles that switch style back to back cover the cases where the port must not act.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  localparam int AD_W = 8;

  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_PULSE = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic            as;
    logic            ds;
    logic            rw;
    logic            cs_n;
    logic [AD_W-1:0] ad;
  } pin_s;

  localparam int PIN_W = $bits(pin_s);

  // style chosen by the data-strobe level seen at the address edge
  function automatic bus_mode_e f_mode_of(input logic ds_level);
    return ds_level ? MODE_PULSE : MODE_LEVEL;
  endfunction

  // byte address lies inside the storage array
  function automatic logic f_in_range(input logic [AD_W-1:0] a, input int depth);
    return int'(a) < depth;
  endfunction

  // host is currently asking the port to drive the bus
  function automatic logic f_read_req(input bus_mode_e m, input logic ds,
                                      input logic rw, input logic as_lvl,
                                      input logic sel);
    logic req;
    if (m == MODE_LEVEL) req = ds & rw;
    else                 req = ~ds & rw;
    return req & ~as_lvl & sel;
  endfunction

  // trailing edge of a write in the current style
  function automatic logic f_write_edge(input bus_mode_e m,
                                        input logic ds, input logic ds_prev,
                                        input logic rw, input logic rw_prev,
                                        input logic as_lvl, input logic sel);
    logic ev;
    if (m == MODE_LEVEL) ev = ds_prev & ~ds & ~rw_prev;
    else                 ev = ~rw_prev & rw;
    return ev & ~as_lvl & sel;
  endfunction
endpackage

// File: rtl/mbp_sync.sv
module mbp_sync #(
  parameter int              W       = 12,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d_async[i];
        stab_q <= meta_q;
      end
    end
    assign d_sync[i] = stab_q;
  end
endmodule

// File: rtl/mbp_cycle_ctrl.sv
module mbp_cycle_ctrl
  import mbp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pin_s            pins_s,
  output bus_mode_e       mode_q,
  output logic [AD_W-1:0] addr_q,
  output logic            sel_q,
  output logic            as_fall,
  output logic            rd_act,
  output logic            wr_stb,
  output logic [AD_W-1:0] wr_data
);
  logic            as_prev;
  logic            ds_prev;
  logic            rw_prev;
  logic [AD_W-1:0] ad_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_prev <= 1'b0;
      ds_prev <= 1'b0;
      rw_prev <= 1'b1;
      ad_prev <= '0;
    end else begin
      as_prev <= pins_s.as;
      ds_prev <= pins_s.ds;
      rw_prev <= pins_s.rw;
      ad_prev <= pins_s.ad;
    end
  end

  assign as_fall = as_prev & ~pins_s.as;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_LEVEL;
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else if (as_fall) begin
      mode_q <= f_mode_of(pins_s.ds);
      addr_q <= pins_s.ad;
      sel_q  <= ~pins_s.cs_n;
    end
  end

  assign rd_act  = f_read_req(mode_q, pins_s.ds, pins_s.rw, pins_s.as, sel_q);
  assign wr_stb  = f_write_edge(mode_q, pins_s.ds, ds_prev, pins_s.rw, rw_prev,
                                pins_s.as, sel_q);
  assign wr_data = ad_prev;
endmodule

// File: rtl/mbp_regfile.sv
module mbp_regfile
  import mbp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] addr,
  input  logic            wr_en,
  input  logic [AD_W-1:0] wr_data,
  output logic [AD_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [AD_W-1:0]  mem_q [DEPTH];
  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = f_in_range(addr, DEPTH);
  assign idx = addr[IDX_W-1:0];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       mem_q[e] <= '0;
      else if (wr_en && hit && idx == IDX_W'(e))        mem_q[e] <= wr_data;
    end
  end

  assign rd_data = hit ? mem_q[idx] : '0;
endmodule

// File: rtl/mbp_host_port.sv
module mbp_host_port
  import mbp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_as,
  input  logic            bus_ds,
  input  logic            bus_rw,
  input  logic            bus_cs_n,
  input  logic [AD_W-1:0] bus_ad_in,
  output logic [AD_W-1:0] bus_ad_out,
  output logic            bus_ad_oe
);
  localparam pin_s PIN_IDLE = '{as: 1'b0, ds: 1'b0, rw: 1'b1, cs_n: 1'b1, ad: '0};

  pin_s            pins_raw;
  pin_s            pins_s;
  bus_mode_e       mode_q;
  logic [AD_W-1:0] addr_q;
  logic            sel_q;
  logic            as_fall;
  logic            rd_act;
  logic            wr_stb;
  logic [AD_W-1:0] wr_data;
  logic [AD_W-1:0] rd_data;

  assign pins_raw = '{as: bus_as, ds: bus_ds, rw: bus_rw, cs_n: bus_cs_n, ad: bus_ad_in};

  mbp_sync #(.W(PIN_W), .RST_VAL(PIN_IDLE)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pins_raw),
    .d_sync  (pins_s)
  );

  mbp_cycle_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_s  (pins_s),
    .mode_q  (mode_q),
    .addr_q  (addr_q),
    .sel_q   (sel_q),
    .as_fall (as_fall),
    .rd_act  (rd_act),
    .wr_stb  (wr_stb),
    .wr_data (wr_data)
  );

  mbp_regfile #(.DEPTH(DEPTH)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr_q),
    .wr_en   (wr_stb),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  assign bus_ad_oe  = rd_act;
  assign bus_ad_out = rd_act ? rd_data : '0;
endmodule

// File: rtl/mbp_host_port_chk.sv
module mbp_host_port_chk
  import mbp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            as_s,
  input logic            as_fall,
  input logic            wr_stb,
  input logic            sel_q,
  input bus_mode_e       mode_q,
  input logic [AD_W-1:0] addr_q,
  input logic            ad_oe,
  input logic [AD_W-1:0] ad_out
);
  // R7: no driving during the address phase
  a_r7_quiet_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !as_s);
  // R7: no driving while a write is taken
  a_r7_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !ad_oe);
  // R2: style only changes at the address edge
  a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !as_fall |=> $stable(mode_q));
  // R1: address only changes at the address edge
  a_r1_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !as_fall |=> $stable(addr_q));
  // R8: out-of-range reads return zero
  a_r8_oor_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && int'(addr_q) >= DEPTH) |-> ad_out == '0);
  // R9: deselected cycles neither drive nor write
  a_r9_deselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> (!ad_oe && !wr_stb));
endmodule

bind mbp_host_port mbp_host_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .as_s    (pins_s.as),
  .as_fall (as_fall),
  .wr_stb  (wr_stb),
  .sel_q   (sel_q),
  .mode_q  (mode_q),
  .addr_q  (addr_q),
  .ad_oe   (bus_ad_oe),
  .ad_out  (bus_ad_out)
);

// File: tb/tb_mbp_host_port.sv
module tb_mbp_host_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_as = 1'b0;
  logic       bus_ds = 1'b0;
  logic       bus_rw = 1'b1;
  logic       bus_cs_n = 1'b1;
  logic [7:0] bus_ad_in = 8'h00;
  logic [7:0] bus_ad_out;
  logic       bus_ad_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] model [64];

  always #2 clk = ~clk;

  mbp_host_port dut (
    .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_ds(bus_ds), .bus_rw(bus_rw),
    .bus_cs_n(bus_cs_n), .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 29 + seed) & 255);
  endfunction

  function automatic logic [7:0] expect_rd(input int a);
    return (a < 64) ? model[a] : 8'h00;
  endfunction

  // address phase; ds level chooses style (R2), address inverted afterwards (R1)
  task automatic addr_phase(input int a, input bit pulse, input bit sel);
    bus_cs_n  = ~sel;
    bus_ds    = pulse;
    bus_rw    = 1'b1;
    bus_ad_in = 8'(a);
    bus_as    = 1'b1;
    tick(5);
    chk("R7 oe during address phase", {1'b0, bus_ad_oe}, 9'h0);
    bus_as = 1'b0;
    tick(2);
    bus_ad_in = ~8'(a);
    tick(3);
  endtask

  task automatic do_write(input int a, input logic [7:0] d, input bit pulse, input bit sel);
    addr_phase(a, pulse, sel);
    bus_ad_in = ~d;
    if (pulse) bus_rw = 1'b0;
    else begin bus_rw = 1'b0; bus_ds = 1'b1; end
    tick(4);
    bus_ad_in = d;
    tick(4);
    chk(pulse ? "R7 oe during pulse write" : "R7 oe during level write",
        {1'b0, bus_ad_oe}, 9'h0);
    if (pulse) bus_rw = 1'b1;
    else       bus_ds = 1'b0;
    tick(5);
    bus_ad_in = 8'h3C;
    bus_rw = 1'b1;
    bus_cs_n = 1'b1;
    tick(3);
    if (sel && a < 64) model[a] = d;
  endtask

  task automatic do_read(input int a, input bit pulse, input bit sel, input string req);
    addr_phase(a, pulse, sel);
    bus_ds = ~pulse;
    tick(6);
    if (sel) chk(req, {bus_ad_oe, bus_ad_out}, {1'b1, expect_rd(a)});
    else     chk("R9 deselected read drives", {1'b0, bus_ad_oe}, 9'h0);
    bus_ds = pulse;
    tick(6);
    chk("R3/R5 release after read", {1'b0, bus_ad_oe}, 9'h0);
    bus_ds = 1'b0;
    bus_cs_n = 1'b1;
    tick(3);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog expired actual=running expected=finished");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    tick(3);
    chk("R10 oe in reset", {1'b0, bus_ad_oe}, 9'h0);
    rst_n = 1'b1;
    tick(3);
    chk("R10 oe after reset", {1'b0, bus_ad_oe}, 9'h0);
    // R10: all bytes zero after reset
    for (int a = 0; a < 64; a++) do_read(a, 1'b0, 1'b1, "R10 reset content");
    // R4 writes, R5 reads (R1, R2)
    for (int a = 0; a < 64; a++) do_write(a, pat(a, 7), 1'b0, 1'b1);
    for (int a = 0; a < 64; a++) do_read(a, 1'b1, 1'b1, "R5 R4 pulse read of level write");
    // R6 writes, R3 reads
    for (int a = 0; a < 64; a++) do_write(a, pat(a, 91), 1'b1, 1'b1);
    for (int a = 0; a < 64; a++) do_read(a, 1'b0, 1'b1, "R3 R6 level read of pulse write");
    // R8: out-of-range writes ignored, reads zero
    for (int a = 64; a < 256; a += 13) begin
      do_write(a, 8'hA5, a[0], 1'b1);
      do_read(a, ~a[0], 1'b1, "R8 out-of-range read zero");
      do_read(a & 63, 1'b0, 1'b1, "R8 alias byte unchanged");
    end
    // R9: deselected cycles
    for (int a = 0; a < 64; a += 9) begin
      do_write(a, 8'h5A, a[0], 1'b0);
      do_read(a, a[0], 1'b0, "R9");
      do_read(a, ~a[0], 1'b1, "R9 byte kept after deselected write");
    end
    // R2: style switches cycle by cycle
    for (int a = 0; a < 16; a++) begin
      do_write(a, pat(a, 200), a[0], 1'b1);
      do_read(a, ~a[0], 1'b1, "R2 alternating style");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule